// File: doc/BRIEF.md
# Multi-Level Virtual Address Translation Walker

This block turns a 64-bit virtual address into a 64-bit real address by reading translation tables from memory. The tables form a hierarchy of up to five levels: three region levels (first, second, third), a segment level and a page level. A control word that comes with each request (the space descriptor) gives the origin and level of the top table. The walk starts at that level and skips every level above it. A descriptor that marks a real space makes the block return the virtual address unchanged, with no table read at all.

The walker has a single 8-byte read port toward memory. Only one read is in flight at a time. At each level it checks the invalid and table-type bits and the offset/length bounds that the entry places on the next table. It keeps the segment protection bit and combines it with the page protection bit to refuse stores. Each translation ends with a one-cycle completion pulse. The pulse carries either the real address or a fault code, and a copy of the store flag of the request.

The virtual address is split from the top down into the region-first index [63:53], region-second index [52:42], region-third index [41:31], segment index [30:20], page index [19:12] and byte index [11:0].

Top module: `dat_walker`

## Requirements
- R1: The entry read for a level goes to the table origin plus the index field of that level times 8. The index fields are the address slices given above. Every read address is 8-byte aligned.
- R2: Descriptor format: origin in bits [63:12] (4 KB aligned), real-space flag in bit 4, start-level code in bits [3:2] (11 region-first, 10 region-second, 01 region-third, 00 segment). The walk reads first at the coded level, so a walk started at level L makes exactly L-level-count reads down to the page.
- R3: When descriptor bit 4 is 1, the result is the virtual address unchanged with fault code 0. No memory read is made, and the completion pulse comes one cycle after the request is accepted.
- R4: A region entry whose type bits [3:2] differ from the code of the level it was read from (same encoding as R2), or a segment entry whose bits [3:2] are not 00, ends the walk with fault code 5.
- R5: Invalid bits end the walk: region entry bit 5 gives fault code 1, segment entry bit 5 gives code 2, page entry bit 10 gives code 3. The invalid bit is checked before the type and bounds checks.
- R6: A store is refused with fault code 6 when segment entry bit 9 or page entry bit 8 is 1. A load through the same entries completes without fault.
- R7: On success the real address is the page entry's frame bits [63:12] joined with the byte index [11:0], and the fault code is 0.
- R8: A region entry carries a table offset in bits [7:6] and a table length in bits [1:0], in 4 KB quarters of the next table. The next table's index bits [10:9] must lie between offset and length inclusive. Otherwise the walk ends with fault code 4 and the next table is not read.
- R9: The completion pulse is high for exactly one cycle per accepted request, and the store flag returned with it equals the request's store flag.
- R10: At most one memory read is outstanding. A read request stays valid with a stable address until memory accepts it, and no read is requested while a new request can be accepted.
- R11: Region entries give the next table origin in bits [63:12]. Segment entries give the page table origin in bits [63:11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_store | input | 1 | Access is a store |
| req_space | input | 64 | Space descriptor (origin, real flag, start level) |
| done | output | 1 | One-cycle completion pulse |
| rsp_raddr | output | 64 | Real address (0 on fault) |
| rsp_fault | output | 3 | Fault code, 0 = none |
| rsp_store | output | 1 | Store flag of the completed request |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The bench walks from each of the region-first, region-third and segment start levels. Each walk is measured by its read count, so a walker that ignores the start level shows the wrong count. It sends reads to in-bounds and out-of-bounds quarters of a bounded table. A walker that skips the bound check, or checks it only after the read, gives a wrong fault or one read too many. Stores and loads go through segment-protected and page-protected entries, which catches protection applied to loads or a segment bit that is forgotten by the page level. Real-space requests must show zero reads and the unchanged address. The memory model stalls every other cycle, so a walker that drops or changes a pending read fails.

// File: rtl/dat_walk_pkg.sv
package dat_walk_pkg;
  localparam int AW     = 64;
  localparam int IDX_W  = 11;
  localparam int PX_W   = 8;
  localparam int BX_W   = 12;
  localparam int ENT_LG = 3;   // log2 of entry bytes
  localparam int TBL_LG = 12;  // region/segment table origin alignment
  localparam int PT_LG  = 11;  // page table origin alignment
  localparam int Q_W    = 2;   // quarter index width for bounds

  typedef enum logic [2:0] {
    LV_PAGE = 3'd0, LV_SEG = 3'd1, LV_R3 = 3'd2, LV_R2 = 3'd3, LV_R1 = 3'd4
  } level_e;

  typedef enum logic [2:0] {
    F_NONE = 3'd0, F_REG_INV = 3'd1, F_SEG_INV = 3'd2, F_PG_INV = 3'd3,
    F_LENGTH = 3'd4, F_TYPE = 3'd5, F_PROT = 3'd6
  } fault_e;

  function automatic logic [IDX_W-1:0] field_of(input logic [AW-1:0] va, input level_e lv);
    logic [IDX_W-1:0] f;
    case (lv)
      LV_R1:   f = va[BX_W+PX_W+4*IDX_W-1 -: IDX_W];
      LV_R2:   f = va[BX_W+PX_W+3*IDX_W-1 -: IDX_W];
      LV_R3:   f = va[BX_W+PX_W+2*IDX_W-1 -: IDX_W];
      LV_SEG:  f = va[BX_W+PX_W+IDX_W-1 -: IDX_W];
      default: f = {{(IDX_W-PX_W){1'b0}}, va[BX_W+PX_W-1 -: PX_W]};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/dat_entry_addr.sv
module dat_entry_addr
  import dat_walk_pkg::*;
(
  input  logic [AW-1:0] vaddr,
  input  level_e        level,
  input  logic [AW-1:0] origin,
  output logic [AW-1:0] entry_addr
);
  localparam int PAD = AW - IDX_W - ENT_LG;
  logic [IDX_W-1:0] idx;
  assign idx        = field_of(vaddr, level);
  assign entry_addr = origin + {{PAD{1'b0}}, idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/dat_entry_eval.sv
module dat_entry_eval
  import dat_walk_pkg::*;
(
  input  logic [AW-1:0] entry,
  input  level_e        level,
  input  logic [AW-1:0] vaddr,
  input  logic          is_store,
  input  logic          seg_prot_in,
  output fault_e        fault,
  output logic [AW-1:0] next_origin,
  output logic          seg_prot_out,
  output logic [AW-1:0] real_addr
);
  localparam int INV_R  = 5;
  localparam int INV_P  = 10;
  localparam int PROT_S = 9;
  localparam int PROT_P = 8;

  logic [IDX_W-1:0] nidx;
  logic [Q_W-1:0]   quarter, t_off, t_len;
  logic [1:0]       want_tt;
  logic             oob;

  assign nidx    = field_of(vaddr, level_e'(level - 3'd1));
  assign quarter = nidx[IDX_W-1 -: Q_W];
  assign t_off   = entry[7:6];
  assign t_len   = entry[1:0];
  assign oob     = (quarter < t_off) || (quarter > t_len);
  assign want_tt = 2'(level - 3'd1);

  always_comb begin
    fault        = F_NONE;
    next_origin  = '0;
    seg_prot_out = seg_prot_in;
    real_addr    = '0;
    case (level)
      LV_PAGE: begin
        if (entry[INV_P])                                  fault = F_PG_INV;
        else if (is_store && (seg_prot_in || entry[PROT_P])) fault = F_PROT;
        real_addr = {entry[AW-1:BX_W], vaddr[BX_W-1:0]};
      end
      LV_SEG: begin
        if (entry[INV_R])               fault = F_SEG_INV;
        else if (entry[3:2] != 2'b00)   fault = F_TYPE;
        next_origin  = {entry[AW-1:PT_LG], {PT_LG{1'b0}}};
        seg_prot_out = entry[PROT_S];
      end
      default: begin
        if (entry[INV_R])               fault = F_REG_INV;
        else if (entry[3:2] != want_tt) fault = F_TYPE;
        else if (oob)                   fault = F_LENGTH;
        next_origin = {entry[AW-1:TBL_LG], {TBL_LG{1'b0}}};
      end
    endcase
  end
endmodule

// File: rtl/dat_walker.sv
module dat_walker
  import dat_walk_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [63:0]   req_vaddr,
  input  logic          req_store,
  input  logic [63:0]   req_space,
  output logic          done,
  output logic [63:0]   rsp_raddr,
  output logic [2:0]    rsp_fault,
  output logic          rsp_store,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [63:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} state_e;

  state_e        state;
  level_e        level;
  logic [AW-1:0] va_q, origin_q;
  logic          store_q, seg_prot_q;

  fault_e        ev_fault;
  logic [AW-1:0] ev_next, ev_real;
  logic          ev_sprot;

  dat_entry_addr u_addr (
    .vaddr(va_q), .level(level), .origin(origin_q), .entry_addr(mem_req_addr)
  );

  dat_entry_eval u_eval (
    .entry(mem_rsp_data), .level(level), .vaddr(va_q), .is_store(store_q),
    .seg_prot_in(seg_prot_q), .fault(ev_fault), .next_origin(ev_next),
    .seg_prot_out(ev_sprot), .real_addr(ev_real)
  );

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      level      <= LV_PAGE;
      va_q       <= '0;
      origin_q   <= '0;
      store_q    <= 1'b0;
      seg_prot_q <= 1'b0;
      done       <= 1'b0;
      rsp_raddr  <= '0;
      rsp_fault  <= F_NONE;
      rsp_store  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va_q       <= req_vaddr;
          store_q    <= req_store;
          seg_prot_q <= 1'b0;
          if (req_space[4]) begin
            done      <= 1'b1;
            rsp_raddr <= req_vaddr;
            rsp_fault <= F_NONE;
            rsp_store <= req_store;
          end else begin
            level    <= level_e'({1'b0, req_space[3:2]} + 3'd1);
            origin_q <= {req_space[AW-1:TBL_LG], {TBL_LG{1'b0}}};
            state    <= S_FETCH;
          end
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (ev_fault != F_NONE || level == LV_PAGE) begin
            done      <= 1'b1;
            rsp_fault <= ev_fault;
            rsp_raddr <= (ev_fault == F_NONE) ? ev_real : '0;
            rsp_store <= store_q;
            state     <= S_IDLE;
          end else begin
            origin_q   <= ev_next;
            level      <= level_e'(level - 3'd1);
            seg_prot_q <= ev_sprot;
            state      <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dat_walker_chk.sv
module dat_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_vaddr,
  input logic [63:0] req_space,
  input logic        done,
  input logic [63:0] rsp_raddr,
  input logic [2:0]  rsp_fault,
  input logic        rsp_store,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  a_r6_prot_store: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_fault == 3'd6) |-> rsp_store);

  a_r3_real_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_space[4]) |=>
      (done && rsp_fault == 3'd0 && rsp_raddr == $past(req_vaddr)));
endmodule

bind dat_walker dat_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_space(req_space), .done(done),
  .rsp_raddr(rsp_raddr), .rsp_fault(rsp_fault), .rsp_store(rsp_store),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/dat_walker_tb_top.sv
module dat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_store;
  logic [63:0] req_vaddr, req_space;
  logic        done, rsp_store;
  logic [63:0] rsp_raddr;
  logic [2:0]  rsp_fault;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_req_addr, mem_rsp_data;

  logic [63:0] mem [logic [63:0]];
  int          total_reads;
  int          n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  dat_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .req_space(req_space),
    .done(done), .rsp_raddr(rsp_raddr), .rsp_fault(rsp_fault),
    .rsp_store(rsp_store), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model: accepts every other cycle, answers one cycle after acceptance
  always @(posedge clk) begin
    if (rst) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      total_reads   <= 0;
    end else begin
      mem_req_ready <= ~mem_req_ready;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
        total_reads  <= total_reads + 1;
      end
    end
  end

  function automatic logic [63:0] mkva(input logic [10:0] f1, input logic [10:0] f2,
      input logic [10:0] f3, input logic [10:0] sx, input logic [7:0] px, input logic [11:0] bx);
    return {f1, f2, f3, sx, px, bx};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] o_raddr;
  logic [2:0]  o_fault;
  logic        o_store;
  int          o_reads;

  task automatic walk(input logic [63:0] va, input logic st, input logic [63:0] sp);
    int r0, n;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st; req_space = sp;
    r0 = total_reads;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    if (!done) check(1'b0, "R9 completion timeout", 64'(n), 64'd0);
    o_raddr = rsp_raddr; o_fault = rsp_fault; o_store = rsp_store;
    o_reads = total_reads - r0;
    @(negedge clk);
    check(done == 1'b0, "R9 pulse one cycle", 64'(done), 64'd0);
  endtask

  localparam logic [63:0] SP_R1  = 64'h1000C;
  localparam logic [63:0] SP_R3  = 64'h30004;
  localparam logic [63:0] SP_SEG = 64'h40000;
  localparam logic [63:0] FRAME  = 64'hABCDE000;

  task automatic t_reset;
    check(done == 1'b0 && req_ready == 1'b1 && mem_req_valid == 1'b0,
          "R10 reset idle", {61'd0, done, req_ready, mem_req_valid}, 64'b010);
  endtask

  task automatic t_full_walk;
    walk(mkva(0, 1, 3, 11'h00F, 8'h22, 12'h2A8), 1'b0, SP_R1);
    check(o_raddr == (FRAME | 64'h2A8) && o_fault == 0, "R7 full walk addr", o_raddr, FRAME | 64'h2A8);
    check(o_reads == 5, "R1 R11 five reads", 64'(o_reads), 64'd5);
    check(o_store == 1'b0, "R9 store flag load", 64'(o_store), 64'd0);
    walk(mkva(0, 1, 3, 11'h00F, 8'h22, 12'h001), 1'b1, SP_R1);
    check(o_fault == 0 && o_store == 1'b1, "R6 R9 unprotected store", {o_fault, o_store}, 64'b0001);
  endtask

  task automatic t_start_levels;
    walk(mkva(0, 0, 3, 11'h00F, 8'h22, 12'h2A8), 1'b0, SP_R3);
    check(o_reads == 3 && o_raddr == (FRAME | 64'h2A8), "R2 start region-third", 64'(o_reads), 64'd3);
    walk(mkva(0, 0, 0, 11'h00F, 8'h22, 12'h123), 1'b0, SP_SEG);
    check(o_reads == 2 && o_raddr == (FRAME | 64'h123), "R2 start segment", 64'(o_reads), 64'd2);
  endtask

  task automatic t_real;
    walk(64'hDEAD_BEEF_0123_4567, 1'b1, 64'h10);
    check(o_raddr == 64'hDEAD_BEEF_0123_4567 && o_fault == 0, "R3 real pass", o_raddr, 64'hDEAD_BEEF_0123_4567);
    check(o_reads == 0, "R3 real no reads", 64'(o_reads), 64'd0);
  endtask

  task automatic t_type;
    walk(mkva(0, 1, 3, 11'h00F, 8'h22, 0), 1'b0, 64'h30008);
    check(o_fault == 5 && o_reads == 1, "R4 type mismatch", 64'(o_fault), 64'd5);
  endtask

  task automatic t_invalid;
    walk(mkva(1, 1, 3, 11'h00F, 8'h22, 0), 1'b0, SP_R1);
    check(o_fault == 1 && o_reads == 1, "R5 region invalid", 64'(o_fault), 64'd1);
    walk(mkva(0, 1, 3, 11'h010, 8'h22, 0), 1'b0, SP_R1);
    check(o_fault == 2 && o_reads == 4, "R5 segment invalid", 64'(o_fault), 64'd2);
    walk(mkva(0, 1, 3, 11'h00F, 8'h23, 0), 1'b0, SP_R1);
    check(o_fault == 3 && o_raddr == 0, "R5 page invalid", 64'(o_fault), 64'd3);
  endtask

  task automatic t_protect;
    walk(mkva(0, 1, 3, 11'h011, 8'h22, 12'h010), 1'b1, SP_R1);
    check(o_fault == 6, "R6 segment protect store", 64'(o_fault), 64'd6);
    walk(mkva(0, 1, 3, 11'h011, 8'h22, 12'h010), 1'b0, SP_R1);
    check(o_fault == 0 && o_raddr == (FRAME | 64'h010), "R6 segment protect load", o_raddr, FRAME | 64'h010);
    walk(mkva(0, 1, 3, 11'h00F, 8'h24, 12'h020), 1'b1, SP_R1);
    check(o_fault == 6, "R6 page protect store", 64'(o_fault), 64'd6);
    walk(mkva(0, 1, 3, 11'h00F, 8'h24, 12'h020), 1'b0, SP_R1);
    check(o_fault == 0 && o_raddr == 64'hABCDF020, "R6 page protect load", o_raddr, 64'hABCDF020);
  endtask

  task automatic t_length;
    walk(mkva(0, 1, 4, 11'h00F, 8'h22, 0), 1'b0, SP_R1);
    check(o_fault == 4, "R8 below offset fault", 64'(o_fault), 64'd4);
    check(o_reads == 3, "R8 no read past bound", 64'(o_reads), 64'd3);
    walk(mkva(0, 1, 4, 11'h20F, 8'h22, 12'h2A8), 1'b0, SP_R1);
    check(o_fault == 0 && o_raddr == (FRAME | 64'h2A8), "R8 inside bound", o_raddr, FRAME | 64'h2A8);
    walk(mkva(0, 1, 4, 11'h60F, 8'h22, 0), 1'b0, SP_R1);
    check(o_fault == 4, "R8 above length fault", 64'(o_fault), 64'd4);
  endtask

  bit finished = 0;

  initial begin
    mem[64'h10000] = 64'h2000F;              // R1[0]: next 0x20000, tt 11, len 3
    mem[64'h10008] = 64'h00020;              // R1[1]: invalid
    mem[64'h20008] = 64'h3000B;              // R2[1]: next 0x30000, tt 10
    mem[64'h30018] = 64'h40007;              // R3[3]: next seg 0x40000, tt 01
    mem[64'h30020] = 64'h40000 | 64'h46;     // R3[4]: off 1, len 2, tt 01
    mem[64'h40078] = 64'h50000;              // SEG[0x0F]
    mem[64'h40080] = 64'h00020;              // SEG[0x10]: invalid
    mem[64'h40088] = 64'h50200;              // SEG[0x11]: protected
    mem[64'h41078] = 64'h50000;              // SEG[0x20F]
    mem[64'h50110] = FRAME;                  // PT[0x22]
    mem[64'h50118] = 64'h400;                // PT[0x23]: invalid
    mem[64'h50120] = 64'hABCDF100;           // PT[0x24]: protected
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_vaddr = '0; req_space = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_start_levels();
    t_real();
    t_type();
    t_invalid();
    t_protect();
    t_length();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule